// File: doc/BRIEF.md
# Memory Access Cycle Accounting Unit

This block keeps running performance totals for a data cache. It takes one record per memory access. Each record carries a load or store flag, the number of instructions retired since the previous access (the access instruction included), a hit flag and a flag that marks a dirty victim. From these records the block keeps eight counters: total execution cycles, instructions, accesses, load hits, load misses, store hits, store misses and dirty evictions.

The cycle cost of a record has three parts. Each instruction adds one base cycle. Each miss adds a stall equal to the miss-penalty input. A miss that evicts a dirty line also adds the dirty-delay input, which models the write-buffer delay. Both cost inputs are read together with the record, so software can change them between records. Miss rates and CPI are left to whatever reads the counters.

Records arrive on a valid/ready handshake. A synchronous clear input zeroes all counters and holds ready low while it is asserted.

Top module: `mem_cycle_acct`

## Requirements
- R1: After reset (rst_ni low), all eight counter outputs read zero.
- R2: Each accepted record adds its instruction count to the instruction counter.
- R3: Each accepted record adds its instruction count to the cycle counter, as one base cycle per instruction.
- R4: A miss (hit flag 0) adds the value on miss_pen_i in the accepting cycle to the cycle counter, and a hit adds no stall. A later change of miss_pen_i affects only later records.
- R5: A miss whose dirty flag is 1 adds the value on dirty_dly_i on top of the penalty and increments the dirty-eviction counter. The dirty flag of a hit is ignored: it adds no cycles and does not count.
- R6: The store flag is 0 for a load and 1 for a store. Each accepted record increments exactly one of load hits, load misses, store hits or store misses.
- R7: The access counter increments once per accepted record (valid and ready both high). No counter changes while valid is low.
- R8: While clear_i is high, rec_ready_o is low. All counters read zero after the clock edge that sees clear_i, and a record offered during clear is not counted.
- R9: With a penalty of 30, a trace of 31 instructions holding 4 clean misses and 3 hits totals 151 cycles. Each counter shows a record's effect in the cycle after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of all counters |
| rec_valid_i | input | 1 | Record valid |
| rec_ready_o | output | 1 | Record can be accepted (low during clear) |
| rec_store_i | input | 1 | 0 = load, 1 = store |
| rec_icount_i | input | ICW (16) | Instructions since the previous access, this one included |
| rec_hit_i | input | 1 | 1 = cache hit |
| rec_dirty_i | input | 1 | 1 = victim line dirty (used on miss only) |
| miss_pen_i | input | PW (8) | Miss stall in cycles |
| dirty_dly_i | input | DW (4) | Extra cycles for a dirty victim |
| cycles_o | output | CYW (48) | Total execution cycles |
| instrs_o | output | CTW (40) | Total instructions |
| accesses_o | output | CTW (40) | Accepted records |
| load_hits_o | output | CTW (40) | Load hits |
| load_misses_o | output | CTW (40) | Load misses |
| store_hits_o | output | CTW (40) | Store hits |
| store_misses_o | output | CTW (40) | Store misses |
| dirty_evict_o | output | CTW (40) | Misses with a dirty victim |

## Verification
Every counter is a single register stage. A record's effect is therefore visible one clock after the rising edge that accepts it, and a clear takes effect one clock after the edge that sees it. The bench drives each record on a falling edge and updates its behavioural model at the next rising edge. It then compares all eight counters on the following falling edge, which is the first point at which the new totals are due. rec_ready_o is combinational from clear_i, so it is checked in the same cycle the stimulus is applied.

// File: rtl/mca_pkg.sv
package mca_pkg;
  localparam int unsigned EV_ACC      = 0;
  localparam int unsigned EV_LD_HIT   = 1;
  localparam int unsigned EV_LD_MISS  = 2;
  localparam int unsigned EV_ST_HIT   = 3;
  localparam int unsigned EV_ST_MISS  = 4;
  localparam int unsigned EV_DIRTY    = 5;
  localparam int unsigned NUM_EV      = 6;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/mca_cost.sv
module mca_cost
  import mca_pkg::*;
#(
  parameter int unsigned ICW = 16,
  parameter int unsigned PW  = 8,
  parameter int unsigned DW  = 4,
  parameter int unsigned CW  = 18
) (
  input  logic           store_i,
  input  logic [ICW-1:0] icount_i,
  input  logic           hit_i,
  input  logic           dirty_i,
  input  logic [PW-1:0]  pen_i,
  input  logic [DW-1:0]  dly_i,
  output logic [CW-1:0]  cost_o,
  output logic [NUM_EV-1:0] ev_o
);
  logic miss, dirty_miss;

  assign miss       = ~hit_i;
  assign dirty_miss = miss & dirty_i;  // victim flag meaningless on hit

  always_comb begin
    cost_o = CW'(icount_i);
    if (miss)       cost_o = cost_o + CW'(pen_i);
    if (dirty_miss) cost_o = cost_o + CW'(dly_i);
  end

  always_comb begin
    ev_o              = '0;
    ev_o[EV_ACC]      = 1'b1;
    ev_o[EV_LD_HIT]   = ~store_i & hit_i;
    ev_o[EV_LD_MISS]  = ~store_i & miss;
    ev_o[EV_ST_HIT]   =  store_i & hit_i;
    ev_o[EV_ST_MISS]  =  store_i & miss;
    ev_o[EV_DIRTY]    = dirty_miss;
  end
endmodule

// File: rtl/mca_acc.sv
module mca_acc #(
  parameter int unsigned W  = 40,
  parameter int unsigned IW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [IW-1:0] inc_i,
  output logic [W-1:0]  sum_o
);
  logic [W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (en_i)  sum_q <= sum_q + W'(inc_i);
  end

  assign sum_o = sum_q;

  a_r8_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> sum_o == '0);

  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(sum_o));

  a_r2_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> sum_o >= $past(sum_o));
endmodule

// File: rtl/mem_cycle_acct.sv
module mem_cycle_acct
  import mca_pkg::*;
#(
  parameter int unsigned ICW = 16,
  parameter int unsigned PW  = 8,
  parameter int unsigned DW  = 4,
  parameter int unsigned CYW = 48,
  parameter int unsigned CTW = 40
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           rec_valid_i,
  output logic           rec_ready_o,
  input  logic           rec_store_i,
  input  logic [ICW-1:0] rec_icount_i,
  input  logic           rec_hit_i,
  input  logic           rec_dirty_i,
  input  logic [PW-1:0]  miss_pen_i,
  input  logic [DW-1:0]  dirty_dly_i,
  output logic [CYW-1:0] cycles_o,
  output logic [CTW-1:0] instrs_o,
  output logic [CTW-1:0] accesses_o,
  output logic [CTW-1:0] load_hits_o,
  output logic [CTW-1:0] load_misses_o,
  output logic [CTW-1:0] store_hits_o,
  output logic [CTW-1:0] store_misses_o,
  output logic [CTW-1:0] dirty_evict_o
);
  localparam int unsigned CW = max3(ICW, PW, DW) + 2;

  logic              accept;
  logic [CW-1:0]     cost;
  logic [NUM_EV-1:0] ev;
  logic [CTW-1:0]    ev_cnt [NUM_EV];

  assign rec_ready_o = ~clear_i;
  assign accept      = rec_valid_i & rec_ready_o;

  mca_cost #(.ICW(ICW), .PW(PW), .DW(DW), .CW(CW)) u_cost (
    .store_i  (rec_store_i),
    .icount_i (rec_icount_i),
    .hit_i    (rec_hit_i),
    .dirty_i  (rec_dirty_i),
    .pen_i    (miss_pen_i),
    .dly_i    (dirty_dly_i),
    .cost_o   (cost),
    .ev_o     (ev)
  );

  mca_acc #(.W(CYW), .IW(CW)) u_cyc (
    .clk_i, .rst_ni, .clr_i(clear_i), .en_i(accept), .inc_i(cost), .sum_o(cycles_o)
  );

  mca_acc #(.W(CTW), .IW(ICW)) u_ins (
    .clk_i, .rst_ni, .clr_i(clear_i), .en_i(accept), .inc_i(rec_icount_i), .sum_o(instrs_o)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    mca_acc #(.W(CTW), .IW(1)) u_ev (
      .clk_i, .rst_ni, .clr_i(clear_i), .en_i(accept & ev[g]), .inc_i(1'b1), .sum_o(ev_cnt[g])
    );
  end

  assign accesses_o     = ev_cnt[EV_ACC];
  assign load_hits_o    = ev_cnt[EV_LD_HIT];
  assign load_misses_o  = ev_cnt[EV_LD_MISS];
  assign store_hits_o   = ev_cnt[EV_ST_HIT];
  assign store_misses_o = ev_cnt[EV_ST_MISS];
  assign dirty_evict_o  = ev_cnt[EV_DIRTY];

  a_r6_outcome_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CTW+2)'(load_hits_o) + (CTW+2)'(load_misses_o) + (CTW+2)'(store_hits_o)
      + (CTW+2)'(store_misses_o) == (CTW+2)'(accesses_o));

  a_r5_dirty_le_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CTW+1)'(dirty_evict_o) <= (CTW+1)'(load_misses_o) + (CTW+1)'(store_misses_o));

  a_r3_cyc_ge_instr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    64'(cycles_o) >= 64'(instrs_o));

  a_r7_access_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (accesses_o == $past(accesses_o)) || (accesses_o == $past(accesses_o) + 1'b1));

  a_r8_clear_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> accesses_o == '0 && cycles_o == '0);
endmodule

// File: tb/mem_cycle_acct_test.sv
module mem_cycle_acct_test;
  logic clk_i = 1'b0;
  always #10 clk_i = ~clk_i;

  logic        rst_ni, clear_i, rec_valid_i, rec_ready_o, rec_store_i, rec_hit_i, rec_dirty_i;
  logic [15:0] rec_icount_i;
  logic [7:0]  miss_pen_i;
  logic [3:0]  dirty_dly_i;
  logic [47:0] cycles_o;
  logic [39:0] instrs_o, accesses_o, load_hits_o, load_misses_o, store_hits_o, store_misses_o, dirty_evict_o;

  mem_cycle_acct uut (.*);

  longint m_cyc, m_ins, m_acc, m_lh, m_lm, m_sh, m_sm, m_de;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_zero();
    m_cyc = 0; m_ins = 0; m_acc = 0; m_lh = 0; m_lm = 0; m_sh = 0; m_sm = 0; m_de = 0;
  endtask

  task automatic cmp_all();
    chk("R3/R4 cycles", longint'(cycles_o), m_cyc);
    chk("R2 instrs", longint'(instrs_o), m_ins);
    chk("R7 accesses", longint'(accesses_o), m_acc);
    chk("R6 load_hits", longint'(load_hits_o), m_lh);
    chk("R6 load_misses", longint'(load_misses_o), m_lm);
    chk("R6 store_hits", longint'(store_hits_o), m_sh);
    chk("R6 store_misses", longint'(store_misses_o), m_sm);
    chk("R5 dirty_evict", longint'(dirty_evict_o), m_de);
  endtask

  // called at a falling edge; compares one clock later at the next falling edge
  task automatic step(bit v, bit st, int ic, bit h, bit d, int p, int dl, bit c);
    rec_valid_i = v; rec_store_i = st; rec_icount_i = 16'(ic);
    rec_hit_i = h; rec_dirty_i = d; miss_pen_i = 8'(p); dirty_dly_i = 4'(dl); clear_i = c;
    #1 chk("R8 ready", longint'(rec_ready_o), longint'(!c));
    @(posedge clk_i);
    if (c) model_zero();
    else if (v) begin
      m_ins += ic; m_acc++;
      m_cyc += ic + (h ? 0 : p + (d ? dl : 0));
      if (!h && d) m_de++;
      if (!st) begin if (h) m_lh++; else m_lm++; end
      else     begin if (h) m_sh++; else m_sm++; end
    end
    @(negedge clk_i);
    cmp_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; clear_i = 0; rec_valid_i = 0; rec_store_i = 0; rec_icount_i = 0;
    rec_hit_i = 0; rec_dirty_i = 0; miss_pen_i = 0; dirty_dly_i = 0;
    model_zero();
    repeat (3) @(negedge clk_i);
    cmp_all();  // R1 reset state
    rst_ni = 1;
    @(negedge clk_i);
    cmp_all();  // R1 still zero after release

    // R9 sample trace: 4 clean misses, 3 hits, 31 instructions, penalty 30
    step(1, 0, 1, 0, 0, 30, 2, 0);
    step(1, 0, 10, 0, 0, 30, 2, 0);
    step(1, 0, 3, 0, 0, 30, 2, 0);
    step(1, 1, 4, 1, 0, 30, 2, 0);
    step(1, 0, 6, 1, 0, 30, 2, 0);
    step(1, 0, 3, 0, 0, 30, 2, 0);
    step(1, 1, 4, 1, 0, 30, 2, 0);
    chk("R9 sample total", longint'(cycles_o), 151);
    chk("R9 sample instrs", longint'(instrs_o), 31);

    // R5 dirty-victim miss costs penalty + 2
    step(1, 0, 1, 0, 1, 30, 2, 0);
    chk("R5 dirty miss", longint'(cycles_o), 184);
    // R5 dirty flag on a hit is ignored
    step(1, 1, 2, 1, 1, 30, 2, 0);
    chk("R5 dirty on hit cycles", longint'(cycles_o), 186);
    chk("R5 dirty on hit count", longint'(dirty_evict_o), 1);

    // R7 idle with junk on data lines
    step(0, 1, 99, 0, 1, 200, 15, 0);
    step(0, 0, 7, 0, 0, 30, 2, 0);
    chk("R7 idle", longint'(accesses_o), 9);

    // R4 penalty changed mid-run only affects the later record
    step(1, 1, 5, 0, 0, 100, 2, 0);
    chk("R4 new penalty", longint'(cycles_o), 291);
    step(1, 1, 5, 0, 1, 7, 9, 0);
    chk("R4 R5 small penalty", longint'(cycles_o), 312);

    // R8 clear with a record offered
    step(1, 0, 50, 0, 1, 30, 2, 1);
    chk("R8 cleared", longint'(cycles_o), 0);
    chk("R8 dropped record", longint'(accesses_o), 0);

    // mixed stream, including back-to-back, zero-count, large values
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, $urandom % 2, (i % 50 == 0) ? 65535 : $urandom % 40,
           $urandom % 2, $urandom % 2, $urandom % 256, $urandom % 16, (i % 97) == 96);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule